// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory operation into a stream of per-element byte addresses. A controller pulses `start` with a base address, an element size, a vector length, an addressing mode, a signed stride, a segment member count and a first destination register. The block then issues one request per cycle over a valid/ready handshake. Each request carries its address, the vector register it targets and the element slot inside that register.

Four modes are supported. In unit-stride mode elements sit back to back. In constant-stride mode a signed stride separates them. In indexed mode each address is the base plus a byte offset taken from a separate index stream. In segment mode each element is a record of several members that lie side by side in memory, and member k of every record goes to register dest+k. When the last request has been accepted the block gives a single-cycle `done` pulse. The memory system, the data path and fault handling are outside this block.

Top module: `vmem_addr_gen`

## Requirements
- R1: Unit-stride mode (`mode`=0): request n has address base + n*E, register `destReg` and element n. E is 1 << `sizeCode`, so codes 0,1,2,3 give 1, 2, 4 and 8 bytes. Addresses wrap modulo 2^ADDR_W.
- R2: Constant-stride mode (`mode`=1): request n has address base + n*stride, with the stride read as two's complement. It targets register `destReg` and element n. A zero stride repeats the base address.
- R3: Indexed mode (`mode`=2): request n has address base + idx_n. idx_n is the n-th word accepted on the index stream and is a byte offset that is neither scaled nor sign-extended. No request for element n appears before idx_n has been accepted, and exactly `vecLen` indices are consumed.
- R4: Segment mode (`mode`=3): with member count M = `segField`+1 (1 to 8), requests go in record order and then member order. Request n = r*M + k has address base + n*E, register (`destReg` + k) mod 2^REG_W and element r. In total vecLen*M requests are issued.
- R5: The block issues exactly `vecLen` requests in modes 0 to 2, and vecLen*M in mode 3. `done` is high for exactly the one cycle after the handshake of the last request, and `reqValid` is low in that cycle.
- R6: If `vecLen` is 0, no request is issued and `done` is high in the cycle after `start`.
- R7: While `reqValid` is high and `reqReady` is low, `reqValid`, `reqAddr`, `reqReg` and `reqElem` keep their values into the next cycle.
- R8: A `start` pulse, or a change of any configuration input, while an operation is running has no effect on that operation's requests.
- R9: During and right after reset, `reqValid`, `idxReady` and `done` are low.
- R10: With `reqReady` held high, requests are issued on back-to-back cycles. Unit-stride requests start in the cycle after `start`. In indexed mode with the index stream always valid, requests start in the second cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the current configuration (taken only when idle) |
| baseAddr | input | ADDR_W | Base byte address |
| sizeCode | input | 2 | Element size code, bytes = 1 << code |
| vecLen | input | VL_W | Elements per destination register |
| mode | input | 2 | 0 unit, 1 stride, 2 indexed, 3 segment |
| stride | input | ADDR_W | Signed byte stride for mode 1 |
| segField | input | SEG_W | Segment members minus one |
| destReg | input | REG_W | First destination register |
| idxValid | input | 1 | Index word valid |
| idxReady | output | 1 | Index word accepted when both are high |
| idxData | input | ADDR_W | Byte offset for indexed mode |
| reqValid | output | 1 | Request valid |
| reqReady | input | 1 | Request accepted when both are high |
| reqAddr | output | ADDR_W | Request byte address |
| reqReg | output | REG_W | Target vector register |
| reqElem | output | VL_W | Target element slot |
| done | output | 1 | One-cycle pulse when the operation ends |

## Verification
The first unit-stride request is visible one cycle after the edge that samples `start`. In indexed mode the first request comes one cycle later, because an index must be fetched first. `done` rises one cycle after the edge that accepts the last request, or after the edge that samples `start` when the length is zero. The bench drives all inputs on the falling edge and checks the outputs a short delay later, before the next rising edge. It counts each request at the falling edge where valid and ready are both seen, and checks `done` at the very next falling edge and its drop one edge after that. Stall stability is checked by comparing each stalled cycle's request fields with those of the following cycle.

// File: rtl/vmag_pkg.sv
package vmag_pkg;

  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_SEG    = 2'd3
  } vmagMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;  // capture configuration, reset counters
    logic idxLoad;  // address <= base + index word
    logic step;     // advance counters and running address
  } vmagStrobe_t;

endpackage

// File: rtl/vmag_dpath.sv
module vmag_dpath
  import vmag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VL_W   = 8,
  parameter int REG_W  = 5,
  parameter int SEG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  vmagStrobe_t       strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [1:0]        sizeCode,
  input  logic [VL_W-1:0]   vecLen,
  input  vmagMode_e         mode,
  input  logic [ADDR_W-1:0] stride,
  input  logic [SEG_W-1:0]  segField,
  input  logic [REG_W-1:0]  destReg,
  input  logic [ADDR_W-1:0] idxData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [REG_W-1:0]  reqReg,
  output logic [VL_W-1:0]   reqElem,
  output logic              lastBeat
);

  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [VL_W-1:0]   ONE_V = {{(VL_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] baseQ, strideQ, sizeQ, addrQ, stepAmt;
  logic [VL_W-1:0]   vlQ, elemQ;
  logic [SEG_W-1:0]  memberMaxQ, memberQ;
  logic [REG_W-1:0]  destQ;
  vmagMode_e         modeQ;
  logic              memberWrap;

  assign memberWrap = (memberQ == memberMaxQ);
  assign stepAmt    = (modeQ == MODE_STRIDE) ? strideQ : sizeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ      <= '0;
      strideQ    <= '0;
      sizeQ      <= ONE_A;
      vlQ        <= '0;
      memberMaxQ <= '0;
      destQ      <= '0;
      modeQ      <= MODE_UNIT;
      addrQ      <= '0;
      elemQ      <= '0;
      memberQ    <= '0;
    end else if (strobe.cfgLoad) begin
      baseQ      <= baseAddr;
      strideQ    <= stride;
      sizeQ      <= ONE_A << sizeCode;
      vlQ        <= vecLen;
      memberMaxQ <= (mode == MODE_SEG) ? segField : '0;
      destQ      <= destReg;
      modeQ      <= mode;
      addrQ      <= baseAddr;
      elemQ      <= '0;
      memberQ    <= '0;
    end else begin
      if (strobe.step) begin
        if (memberWrap) begin
          memberQ <= '0;
          elemQ   <= elemQ + ONE_V;
        end else begin
          memberQ <= memberQ + 1'b1;
        end
      end
      if (strobe.idxLoad) begin
        addrQ <= baseQ + idxData;
      end else if (strobe.step && modeQ != MODE_INDEX) begin
        addrQ <= addrQ + stepAmt;
      end
    end
  end

  assign lastBeat = (elemQ == vlQ - ONE_V) && memberWrap;
  assign reqAddr  = addrQ;
  assign reqReg   = destQ + REG_W'(memberQ);
  assign reqElem  = elemQ;

  // R4
  member_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.cfgLoad && !memberWrap) |=> (elemQ == $past(elemQ)));

  // R5
  elem_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (elemQ < vlQ));

endmodule

// File: rtl/vmag_ctrl.sv
module vmag_ctrl
  import vmag_pkg::*;
#(
  parameter int VL_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [VL_W-1:0] vecLen,
  input  vmagMode_e       mode,
  input  logic            reqReady,
  input  logic            idxValid,
  input  logic            lastBeat,
  output vmagStrobe_t     strobe,
  output logic            reqValid,
  output logic            idxReady,
  output logic            done
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ISSUE} ctrlState_e;

  ctrlState_e state, nextState;
  logic       idxModeQ, doneNext;

  always_comb begin
    strobe    = '0;
    reqValid  = 1'b0;
    idxReady  = 1'b0;
    doneNext  = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.cfgLoad = 1'b1;
          if (vecLen == '0)             doneNext  = 1'b1;
          else if (mode == MODE_INDEX)  nextState = ST_FETCH;
          else                          nextState = ST_ISSUE;
        end
      end
      ST_FETCH: begin
        idxReady = 1'b1;
        if (idxValid) begin
          strobe.idxLoad = 1'b1;
          nextState      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        reqValid = 1'b1;
        // fetch the next index in the same cycle the current request leaves
        idxReady = idxModeQ && !lastBeat && reqReady;
        if (reqReady) begin
          strobe.step = 1'b1;
          if (lastBeat) begin
            doneNext  = 1'b1;
            nextState = ST_IDLE;
          end else if (idxModeQ) begin
            if (idxValid) strobe.idxLoad = 1'b1;
            else          nextState      = ST_FETCH;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idxModeQ <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneNext;
      if (strobe.cfgLoad) idxModeQ <= (mode == MODE_INDEX);
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  last_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && lastBeat) |=> (done && !reqValid));

  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && vecLen == '0) |=> (done && !reqValid));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strobe.cfgLoad);

endmodule

// File: rtl/vmem_addr_gen.sv
module vmem_addr_gen
  import vmag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VL_W   = 8,
  parameter int REG_W  = 5,
  parameter int SEG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [1:0]        sizeCode,
  input  logic [VL_W-1:0]   vecLen,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] stride,
  input  logic [SEG_W-1:0]  segField,
  input  logic [REG_W-1:0]  destReg,
  input  logic              idxValid,
  output logic              idxReady,
  input  logic [ADDR_W-1:0] idxData,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [REG_W-1:0]  reqReg,
  output logic [VL_W-1:0]   reqElem,
  output logic              done
);

  vmagStrobe_t strobe;
  vmagMode_e   modeE;
  logic        lastBeat;

  assign modeE = vmagMode_e'(mode);

  vmag_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen), .mode(modeE),
    .reqReady(reqReady), .idxValid(idxValid), .lastBeat(lastBeat),
    .strobe(strobe), .reqValid(reqValid), .idxReady(idxReady), .done(done)
  );

  vmag_dpath #(.ADDR_W(ADDR_W), .VL_W(VL_W), .REG_W(REG_W), .SEG_W(SEG_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .sizeCode(sizeCode), .vecLen(vecLen), .mode(modeE), .stride(stride),
    .segField(segField), .destReg(destReg), .idxData(idxData),
    .reqAddr(reqAddr), .reqReg(reqReg), .reqElem(reqElem), .lastBeat(lastBeat)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) &&
                                 $stable(reqReg) && $stable(reqElem)));

endmodule

// File: tb/vmem_addr_gen_bench.sv
module vmem_addr_gen_bench;

  localparam int NV = 8;
  localparam int MODE [NV] = '{0, 0, 1, 1, 2, 3, 3, 3};
  localparam int SIZE [NV] = '{2, 0, 3, 1, 1, 2, 0, 3};
  localparam int VLEN [NV] = '{5, 4, 6, 3, 6, 3, 2, 4};
  localparam int STRD [NV] = '{0, 0, -24, 0, 0, 0, 0, 0};
  localparam int SEGF [NV] = '{0, 0, 0, 0, 0, 2, 7, 0};
  localparam int DEST [NV] = '{3, 0, 7, 9, 2, 30, 1, 12};
  localparam logic [31:0] BASE [NV] = '{32'h0000_1000, 32'hFFFF_FFFE, 32'h0000_2000,
                                        32'h0000_0040, 32'h0000_8000, 32'h0000_3000,
                                        32'h0000_5001, 32'h0000_6000};

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] baseAddr = '0, stride = '0, idxData = '0;
  logic [1:0]  sizeCode = '0, mode = '0;
  logic [7:0]  vecLen = '0;
  logic [2:0]  segField = '0;
  logic [4:0]  destReg = '0;
  logic idxValid = 1'b0, reqReady = 1'b0;
  logic idxReady, reqValid, done;
  logic [31:0] reqAddr;
  logic [4:0]  reqReg;
  logic [7:0]  reqElem;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  vmem_addr_gen u_vmem_addr_gen (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .sizeCode(sizeCode),
    .vecLen(vecLen), .mode(mode), .stride(stride), .segField(segField),
    .destReg(destReg), .idxValid(idxValid), .idxReady(idxReady), .idxData(idxData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqReg(reqReg),
    .reqElem(reqElem), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] idxOf(input int n);
    return 32'(n * 52 - 100);
  endfunction

  function automatic string reqOf(input int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // run vector v; fullRate holds ready and index valid high; busyStart pokes start mid-run
  task automatic runVec(input int v, input bit fullRate, input bit busyStart, output int cycles);
    int m, nf, total, n, ip, k;
    logic [31:0] esz, b, expA, holdA;
    logic [4:0]  expR, holdR;
    logic [7:0]  expE, holdE;
    bit stalled;
    m = MODE[v]; nf = (m == 3) ? SEGF[v] + 1 : 1;
    total = VLEN[v] * nf; esz = 32'd1 << SIZE[v]; b = BASE[v];
    baseAddr = b; sizeCode = 2'(SIZE[v]); vecLen = 8'(VLEN[v]); mode = 2'(m);
    stride = 32'(STRD[v]); segField = 3'(SEGF[v]); destReg = 5'(DEST[v]);
    start = 1'b1;
    @(negedge clk);
    start = busyStart;
    if (busyStart) begin
      vecLen = 8'd0; mode = 2'd2; baseAddr = 32'hDEAD_0000; destReg = 5'd17;
    end
    n = 0; ip = 0; k = 0; stalled = 1'b0;
    holdA = '0; holdR = '0; holdE = '0;
    while (n < total && k < 300) begin
      reqReady = fullRate ? 1'b1 : ((k % 3) != 1);
      idxValid = (m == 2) && (ip < VLEN[v]) && (fullRate || (k % 4) != 2);
      idxData  = idxOf(ip);
      #1;
      if (stalled) check(reqValid && reqAddr == holdA && reqReg == holdR && reqElem == holdE,
                         "R7", "stall hold", {reqAddr, 3'b0, reqReg, reqElem},
                         {holdA, 3'b0, holdR, holdE});
      if (reqValid && reqReady) begin
        case (m)
          1:       expA = b + 32'(n) * 32'(STRD[v]);
          2:       expA = b + idxOf(n);
          default: expA = b + 32'(n) * esz;
        endcase
        expR = 5'(DEST[v] + n % nf);
        expE = 8'(n / nf);
        check(reqAddr == expA && reqReg == expR && reqElem == expE, reqOf(m), "request",
              {reqAddr, 3'b0, reqReg, reqElem}, {expA, 3'b0, expR, expE});
        if (m == 2) check(ip > n, "R3", "index before request", 64'(ip), 64'(n + 1));
        n++;
      end
      if (idxReady && idxValid) ip++;
      stalled = reqValid && !reqReady;
      holdA = reqAddr; holdR = reqReg; holdE = reqElem;
      @(negedge clk);
      k++;
    end
    start = 1'b0; reqReady = 1'b0; idxValid = 1'b0;
    cycles = k;
    check(n == total, "R5", "request count", 64'(n), 64'(total));
    if (m == 2) check(ip == VLEN[v], "R3", "indices consumed", 64'(ip), 64'(VLEN[v]));
    check(done && !reqValid, "R5", "done after last", {done, reqValid}, 2'b10);
    @(negedge clk);
    check(!done && !reqValid, "R5", "done single pulse", {done, reqValid}, 2'b00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int cyc;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!reqValid && !idxReady && !done, "R9", "in reset", {reqValid, idxReady, done}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    check(!reqValid && !idxReady && !done, "R9", "after reset", {reqValid, idxReady, done}, 3'b000);

    for (int v = 0; v < NV; v++) runVec(v, 1'b0, 1'b0, cyc);

    // R10 back-to-back rate, unit and indexed
    runVec(0, 1'b1, 1'b0, cyc);
    check(cyc == 5, "R10", "unit cycles", 64'(cyc), 64'd5);
    runVec(4, 1'b1, 1'b0, cyc);
    check(cyc == 7, "R10", "indexed cycles", 64'(cyc), 64'd7);

    // R8 start and config changes while busy are ignored
    runVec(5, 1'b0, 1'b1, cyc);
    runVec(4, 1'b0, 1'b1, cyc);

    // R6 zero length
    vecLen = 8'd0; mode = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; reqReady = 1'b1;
    check(done && !reqValid, "R6", "zero length done", {done, reqValid}, 2'b10);
    @(negedge clk);
    check(!done && !reqValid && !idxReady, "R6", "zero length idle",
          {done, reqValid, idxReady}, 3'b000);
    reqReady = 1'b0;
    // R6 zero length in indexed mode takes no index
    vecLen = 8'd0; mode = 2'd2; start = 1'b1; idxValid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && !reqValid && !idxReady, "R6", "zero length indexed",
          {done, reqValid, idxReady}, 3'b100);
    idxValid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule